// File: doc/BRIEF.md
# Burst Column Order Generator

This block produces the column-offset sequence for a single read or write burst in a DDR4-style memory controller or memory model. A one-cycle launch pulse samples the burst configuration: the two-bit burst-length mode, the ordering select, the per-command chop select, the read/write flag, the write-data-check enable and the three low bits of the starting column. The block then presents one beat per clock for eight clocks. Each beat carries a three-bit column offset, a drive flag and an end-of-burst strobe.

In sequential order the offset wraps inside the current four-beat group. In interleaved order it is the base offset XOR the beat index. A chopped (four-beat) burst still takes the full eight-beat window, but the drive flag is low for its second half. Writes round their base offset down to a group boundary. When write-data checking is on with fixed eight-beat bursts, the base is forced to zero. The reserved length code is refused: the block raises an error pulse and starts no burst.

Top module: `burst_order_gen`

## Requirements
- R1: After reset, beat_act, beat_vld, beat_last and mode_err are all 0.
- R2: The burst-length mode decodes as follows: 2'b00 is always eight beats, 2'b10 is always chopped to four, and 2'b01 takes chop_sel at launch (1 = chopped, 0 = eight beats).
- R3: With ilv_sel = 0 (sequential), beat b has offset {base[2] XOR b[2], (base[1:0] + b[1:0]) mod 4}. For example, base 5 gives 5,6,7,4,1,2,3,0.
- R4: With ilv_sel = 1 (interleaved), beat b has offset base XOR b. For example, base 3 gives 3,2,1,0,7,6,5,4.
- R5: For a read (is_write = 0), the base offset equals col_lo in full.
- R6: For a write, base bits [1:0] are 0 and base bit 2 equals col_lo[2], whatever the burst length.
- R7: For a chopped burst, beat_vld is 1 on beats 0..3 and 0 on beats 4..7, while beat_act stays 1 through beat 7.
- R8: beat_last is 1 on beat 3 of a chopped burst and on beat 7 of an eight-beat burst, and 0 on every other cycle.
- R9: A launch with mode 2'b11 gives mode_err = 1 for exactly one cycle and starts no burst.
- R10: A start pulse arriving while a burst still has beats left is ignored. A start in the cycle that presents beat 7 is accepted, and the next burst follows with no gap.
- R11: When crc_en = 1, a write in mode 2'b00 has base 0 regardless of col_lo. In any other mode, crc_en has no effect.
- R12: Beat 0 appears one clock after the clock edge that samples start, and each burst keeps beat_act high for exactly eight consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch pulse that samples the configuration |
| bl_mode | input | 2 | Burst-length mode: 00 eight, 01 per command, 10 four, 11 reserved |
| ilv_sel | input | 1 | 0 = sequential order, 1 = interleaved order |
| chop_sel | input | 1 | Per-command chop request, used in mode 01 |
| is_write | input | 1 | 1 = write burst, 0 = read burst |
| crc_en | input | 1 | Write-data check enabled |
| col_lo | input | 3 | Low starting column bits |
| beat_ofs | output | 3 | Column offset of the current beat |
| beat_vld | output | 1 | Beat is driven (0 on the silent half of a chopped burst) |
| beat_last | output | 1 | End-of-burst strobe |
| beat_act | output | 1 | Inside an eight-cycle burst window |
| mode_err | output | 1 | Reserved length code refused |

## Verification
The assertions assume that reset is held high before the first clock edge. They also assume that a burst can begin only from idle or right after a beat-7 cycle, so a burst window always spans a multiple of eight cycles and the checker's beat counter stays aligned. The stimulus keeps to this by driving start and the configuration only on falling edges and by holding each launch for exactly one clock. Extra start pulses are injected in the middle of bursts on purpose, because the block must ignore them. Random bursts cover all three legal length codes, both orders, reads and writes, and crc_en on and off. Directed cases add the reserved code and the chained launch.

// File: rtl/bog_pkg.sv
package bog_pkg;
  localparam int unsigned OFS_W = 3;

  typedef enum logic [1:0] {
    BLM_FIX8 = 2'b00,
    BLM_CMD  = 2'b01,
    BLM_FIX4 = 2'b10,
    BLM_RSVD = 2'b11
  } blen_mode_e;

  typedef struct packed {
    logic             ilv;
    logic             chop;
    logic [OFS_W-1:0] base;
  } burst_cfg_t;
endpackage

// File: rtl/bog_cfg_decode.sv
module bog_cfg_decode
  import bog_pkg::*;
#(
  parameter int unsigned COL_W = OFS_W
) (
  input  logic [1:0]       bl_mode,
  input  logic             ilv_sel,
  input  logic             chop_sel,
  input  logic             is_write,
  input  logic             crc_en,
  input  logic [COL_W-1:0] col_lo,
  output burst_cfg_t       cfg,
  output logic             rsvd
);
  localparam int unsigned LOW_W = COL_W - 1;

  blen_mode_e mode;
  assign mode = blen_mode_e'(bl_mode);

  always_comb begin
    rsvd     = (mode == BLM_RSVD);
    cfg.ilv  = ilv_sel;
    cfg.chop = (mode == BLM_FIX4) || ((mode == BLM_CMD) && chop_sel);
    if (!is_write)
      cfg.base = col_lo;
    else if (crc_en && (mode == BLM_FIX8))
      cfg.base = '0;
    else
      cfg.base = {col_lo[COL_W-1], {LOW_W{1'b0}}};
  end
endmodule

// File: rtl/bog_beat_map.sv
module bog_beat_map
  import bog_pkg::*;
#(
  parameter int unsigned COL_W = OFS_W
) (
  input  burst_cfg_t       cfg,
  input  logic [COL_W-1:0] beat,
  output logic [COL_W-1:0] ofs
);
  localparam int unsigned LOW_W = COL_W - 1;

  logic [COL_W-1:0] seq_ofs;
  logic [COL_W-1:0] ilv_ofs;

  generate
    if (LOW_W > 0) begin : g_wrap
      logic [LOW_W-1:0] low_sum;
      assign low_sum = cfg.base[LOW_W-1:0] + beat[LOW_W-1:0];
      assign seq_ofs = {cfg.base[COL_W-1] ^ beat[COL_W-1], low_sum};
    end else begin : g_single
      assign seq_ofs = cfg.base ^ beat;
    end
  endgenerate

  assign ilv_ofs = cfg.base ^ beat;
  assign ofs     = cfg.ilv ? ilv_ofs : seq_ofs;
endmodule

// File: rtl/burst_order_gen.sv
module burst_order_gen
  import bog_pkg::*;
#(
  parameter int unsigned COL_W = OFS_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [1:0]       bl_mode,
  input  logic             ilv_sel,
  input  logic             chop_sel,
  input  logic             is_write,
  input  logic             crc_en,
  input  logic [COL_W-1:0] col_lo,
  output logic [COL_W-1:0] beat_ofs,
  output logic             beat_vld,
  output logic             beat_last,
  output logic             beat_act,
  output logic             mode_err
);
  localparam logic [COL_W-1:0] LAST_BEAT = {COL_W{1'b1}};
  localparam logic [COL_W-1:0] HALF_LAST = {1'b0, {(COL_W-1){1'b1}}};

  burst_cfg_t       dec_cfg;
  burst_cfg_t       cfg_q;
  burst_cfg_t       cur_cfg;
  logic             dec_rsvd;
  logic             running;
  logic [COL_W-1:0] cnt;
  logic [COL_W-1:0] cur_beat;
  logic [COL_W-1:0] map_ofs;
  logic             launch;
  logic             refuse;
  logic             stepping;

  bog_cfg_decode #(.COL_W(COL_W)) u_dec (
    .bl_mode (bl_mode),
    .ilv_sel (ilv_sel),
    .chop_sel(chop_sel),
    .is_write(is_write),
    .crc_en  (crc_en),
    .col_lo  (col_lo),
    .cfg     (dec_cfg),
    .rsvd    (dec_rsvd)
  );

  assign launch   = start && !running && !dec_rsvd;
  assign refuse   = start && !running && dec_rsvd;
  assign stepping = launch || running;
  assign cur_cfg  = launch ? dec_cfg : cfg_q;
  assign cur_beat = launch ? '0 : cnt;

  bog_beat_map #(.COL_W(COL_W)) u_map (
    .cfg (cur_cfg),
    .beat(cur_beat),
    .ofs (map_ofs)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      running <= 1'b0;
      cnt     <= '0;
      cfg_q   <= '0;
    end else if (launch) begin
      running <= 1'b1;
      cnt     <= {{(COL_W-1){1'b0}}, 1'b1};
      cfg_q   <= dec_cfg;
    end else if (running) begin
      cnt <= cnt + 1'b1;
      if (cnt == LAST_BEAT) running <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      beat_ofs  <= '0;
      beat_vld  <= 1'b0;
      beat_last <= 1'b0;
      beat_act  <= 1'b0;
      mode_err  <= 1'b0;
    end else begin
      mode_err <= refuse;
      beat_act <= stepping;
      if (stepping) begin
        beat_ofs  <= map_ofs;
        beat_vld  <= !(cur_cfg.chop && cur_beat[COL_W-1]);
        beat_last <= (cur_beat == (cur_cfg.chop ? HALF_LAST : LAST_BEAT));
      end else begin
        beat_ofs  <= '0;
        beat_vld  <= 1'b0;
        beat_last <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/bog_checker.sv
module bog_checker (
  input logic clk,
  input logic rst,
  input logic beat_act,
  input logic beat_vld,
  input logic beat_last,
  input logic mode_err
);
  logic [2:0] ck;

  always_ff @(posedge clk) begin
    if (rst || !beat_act) ck <= '0;
    else                  ck <= ck + 1'b1;
  end

  // R9: a refused launch never opens a burst window
  a_r9_err_no_burst: assert property (@(posedge clk) disable iff (rst)
    mode_err |-> !beat_act);

  // R8: the end strobe falls only on beat 3 or beat 7 of a window
  a_r8_last_on_boundary: assert property (@(posedge clk) disable iff (rst)
    beat_last |-> (beat_act && (ck == 3'd3 || ck == 3'd7)));

  // R7: after a beat-3 end strobe the following beat is silent
  a_r7_chop_silent: assert property (@(posedge clk) disable iff (rst)
    (beat_last && ck == 3'd3) |=> !beat_vld);

  // R10/R12: a window never closes before its eighth beat
  a_r10_window_full: assert property (@(posedge clk) disable iff (rst)
    (beat_act && ck != 3'd7) |=> beat_act);

  // R7: a driven beat lies inside a burst window
  a_r7_vld_in_window: assert property (@(posedge clk) disable iff (rst)
    beat_vld |-> beat_act);
endmodule

bind burst_order_gen bog_checker u_bog_chk (
  .clk      (clk),
  .rst      (rst),
  .beat_act (beat_act),
  .beat_vld (beat_vld),
  .beat_last(beat_last),
  .mode_err (mode_err)
);

// File: tb/burst_order_gen_tb_top.sv
`timescale 1ns/1ps
module burst_order_gen_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic [1:0] bl_mode = 2'b00;
  logic       ilv_sel = 1'b0;
  logic       chop_sel = 1'b0;
  logic       is_write = 1'b0;
  logic       crc_en = 1'b0;
  logic [2:0] col_lo = 3'd0;
  logic [2:0] beat_ofs;
  logic       beat_vld;
  logic       beat_last;
  logic       beat_act;
  logic       mode_err;

  int n_chk = 0;
  int n_bad = 0;
  bit pending = 1'b0;
  logic [1:0] g_m;
  bit g_il, g_ch, g_wr, g_crc;
  logic [2:0] g_col;

  always #2 clk = ~clk;

  burst_order_gen dut_i (
    .clk(clk), .rst(rst), .start(start), .bl_mode(bl_mode),
    .ilv_sel(ilv_sel), .chop_sel(chop_sel), .is_write(is_write),
    .crc_en(crc_en), .col_lo(col_lo), .beat_ofs(beat_ofs),
    .beat_vld(beat_vld), .beat_last(beat_last), .beat_act(beat_act),
    .mode_err(mode_err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [2:0] exp_base(input logic [1:0] m, input bit wr,
                                          input bit crc, input logic [2:0] col);
    if (!wr) return col;                       // R5
    if (crc && m == 2'b00) return 3'd0;        // R11
    return {col[2], 2'b00};                    // R6
  endfunction

  function automatic logic [2:0] exp_ofs(input logic [2:0] base, input logic [2:0] b,
                                         input bit il);
    logic [1:0] lo;
    lo = base[1:0] + b[1:0];
    if (il) return base ^ b;                   // R4
    return {base[2] ^ b[2], lo};               // R3
  endfunction

  task automatic set_in(input logic [1:0] m, input bit il, ch, wr, crc,
                        input logic [2:0] col);
    bl_mode = m; ilv_sel = il; chop_sel = ch; is_write = wr; crc_en = crc; col_lo = col;
  endtask

  // called at a negedge; inj = beat index at which a stray start is driven (<7)
  task automatic burst(input logic [1:0] m, input bit il, ch, wr, crc,
                       input logic [2:0] col, input int inj, input bit link);
    logic [2:0] base;
    bit chop;
    base = exp_base(m, wr, crc, col);
    chop = (m == 2'b10) || (m == 2'b01 && ch);   // R2
    if (!pending) begin
      set_in(m, il, ch, wr, crc, col);
      start = 1'b1;
    end
    pending = 1'b0;
    @(posedge clk); @(negedge clk);
    start = 1'b0;
    for (int b = 0; b < 8; b++) begin
      chk(beat_act === 1'b1, "R12 window", int'(beat_act), 1);
      chk(beat_vld === !(chop && b >= 4), "R7 drive flag", int'(beat_vld), int'(!(chop && b >= 4)));
      chk(beat_last === (b == (chop ? 3 : 7)), "R8 end strobe", int'(beat_last), int'(b == (chop ? 3 : 7)));
      if (!(chop && b >= 4))
        chk(beat_ofs === exp_ofs(base, 3'(b), il), "R3/R4 offset", int'(beat_ofs),
            int'(exp_ofs(base, 3'(b), il)));
      if (b == inj) begin
        set_in(2'($urandom % 3), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 3'($urandom));
        start = 1'b1;
      end
      if (b == 7) begin
        if (link) begin
          set_in(g_m, g_il, g_ch, g_wr, g_crc, g_col);
          start = 1'b1;
          pending = 1'b1;
        end else begin
          @(negedge clk);
          chk(beat_act === 1'b0, "R10 idle after burst", int'(beat_act), 0);
        end
      end else begin
        @(negedge clk);
        start = 1'b0;
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk + 1 - n_bad, n_chk + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0B0C));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(beat_act === 0 && beat_vld === 0 && beat_last === 0 && mode_err === 0,
        "R1 reset state", int'({beat_act, beat_vld, beat_last, mode_err}), 0);
    rst = 1'b0;
    @(negedge clk);

    // R3 sequential read base 5, R4 interleaved read base 3
    burst(2'b00, 0, 0, 0, 0, 3'd5, -1, 0);
    burst(2'b00, 1, 0, 0, 0, 3'd3, -1, 0);
    // R2 per-command chop and fixed four
    burst(2'b01, 0, 1, 0, 0, 3'd6, -1, 0);
    burst(2'b01, 1, 0, 0, 0, 3'd2, -1, 0);
    burst(2'b10, 1, 0, 0, 0, 3'd7, -1, 0);
    // R6 writes round down, R11 check-enabled write forced to 0, other modes unaffected
    burst(2'b00, 0, 0, 1, 0, 3'd7, -1, 0);
    burst(2'b10, 0, 0, 1, 0, 3'd6, -1, 0);
    burst(2'b00, 0, 0, 1, 1, 3'd6, -1, 0);
    burst(2'b01, 1, 0, 1, 1, 3'd6, -1, 0);

    // R9 reserved code refused
    set_in(2'b11, 0, 0, 0, 0, 3'd1);
    start = 1'b1;
    @(posedge clk); @(negedge clk);
    start = 1'b0;
    chk(mode_err === 1'b1, "R9 error pulse", int'(mode_err), 1);
    chk(beat_act === 1'b0, "R9 no burst", int'(beat_act), 0);
    @(negedge clk);
    chk(mode_err === 1'b0, "R9 single cycle", int'(mode_err), 0);
    chk(beat_act === 1'b0, "R9 still idle", int'(beat_act), 0);

    // R10 stray start mid-burst, then chained launch
    burst(2'b00, 0, 0, 0, 0, 3'd1, 2, 0);
    g_m = 2'b10; g_il = 1; g_ch = 0; g_wr = 0; g_crc = 0; g_col = 3'd5;
    burst(2'b00, 1, 0, 0, 0, 3'd4, -1, 1);
    burst(2'b10, 1, 0, 0, 0, 3'd5, -1, 0);

    // random mix
    begin
      logic [1:0] m;
      bit il, ch, wr, crc;
      logic [2:0] col;
      m = 2'($urandom % 3); il = 1'($urandom); ch = 1'($urandom);
      wr = 1'($urandom); crc = 1'($urandom); col = 3'($urandom);
      for (int i = 0; i < 200; i++) begin
        bit lk;
        int inj;
        lk = (i < 199) && ($urandom % 3 == 0);
        inj = ($urandom % 4 == 0) ? int'($urandom % 7) : -1;
        g_m = 2'($urandom % 3); g_il = 1'($urandom); g_ch = 1'($urandom);
        g_wr = 1'($urandom); g_crc = 1'($urandom); g_col = 3'($urandom);
        burst(m, il, ch, wr, crc, col, inj, lk);
        m = g_m; il = g_il; ch = g_ch; wr = g_wr; crc = g_crc; col = g_col;
      end
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule